// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer with Register Front End

This block sits between a simple register bus and the analog core of a three-input, 10-bit successive-approximation converter. Software sees four word registers: the last conversion code, a busy flag, a control word, and a power-up settling count. Software starts a conversion by writing the control word with the power bit set and an input number in the low field. The block first waits the programmed settling time. It then resolves the code one bit per clock, most significant bit first, by driving a trial code to the external DAC and reading back the comparator.

At the end of a conversion the code is stored, the busy flag drops and a sticky interrupt status bit is set. The interrupt line is raised only while the interrupt enable bit is also set. Software acknowledges the interrupt and powers the core down by writing zero to the control word. If that write arrives while a conversion is running, the conversion is cancelled and the stored code is left as it was.

The sequencer has three states. `ST_IDLE` moves to `ST_SETTLE` on a start when the settling count is non-zero, or straight to `ST_SEARCH` when the count is zero. `ST_SETTLE` moves to `ST_SEARCH` on its last count. `ST_SEARCH` returns to `ST_IDLE` after its tenth step. `ST_SETTLE` and `ST_SEARCH` both return to `ST_IDLE` at once on a cancel.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads zero, the status busy bit is 0, `irq` is 0, `adc_pwr` is 0 and `adc_chan` is 0.
- R2: A write to the control word (byte address 0x8) with bit 3 set while idle starts a conversion. From the clock after that write, status bit 0 (address 0x4) reads 1 for exactly D+10 cycles, where D is the settling count.
- R3: The settling register (address 0xC) keeps only the low 6 bits of a write. A count of 0 makes the first trial happen in the cycle right after the start write.
- R4: The search tests bits 9 down to 0, one per clock. The first trial code is 0x200. A trial bit is kept when `cmp_hi` is 1, meaning the input is at or above the trial code. The final code reads back in bits 9:0 of address 0x0.
- R5: Control bits 2:0 choose the input. Values 0 to 2 select that input, and values 3 to 7 select input 0. The chosen input appears on `adc_chan` from the start write onward.
- R6: At completion, control bit 6 (interrupt status) sets, and `irq` equals that bit AND control bit 5 (interrupt enable).
- R7: Writing zero to the control word clears interrupt status and the power bit, and `irq` and `adc_pwr` go low the next cycle.
- R8: A control write with bit 3 clear during a conversion returns the block to idle at once. The stored code is not updated and interrupt status is not set.
- R9: Unused bits of every register read 0: result bits 31:10, status bits 31:1, control bits 31:7 and bit 4, settling bits 31:6. Any address other than 0x0, 0x4, 0x8 or 0xC reads 0.
- R10: A control write with bit 3 set during a conversion does not restart it. The conversion ends at its original time on its original input, while the written enable and field values take effect in the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |
| adc_pwr | output | 1 | Power enable to the analog core |
| adc_chan | output | 2 | Selected analog input |
| dac_code | output | 10 | Trial code to the DAC, zero outside the search |
| cmp_hi | input | 1 | Comparator result: input at or above the trial code |

## Verification
Conversions are run on inputs at 0, 3, 512, 700 and 1023. These values tell a correct MSB-first keep rule apart from an inverted, shifted or off-by-one search, and the all-ones and all-zeros codes catch stuck bits. Settling counts of 8, 0 and a masked value show whether the busy window is D+10 or one cycle off. Field values 5 and 3, checked against distinct input levels, show whether out-of-range selects fold to input 0. Cancels during settling and during the search, and a power-bit rewrite in mid-conversion, separate cancelling from restarting and from ignoring the write.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SEARCH = 2'd2
    } sar_state_e;

    // register byte offsets
    localparam int OFS_CODE   = 'h0;
    localparam int OFS_STATUS = 'h4;
    localparam int OFS_CTRL   = 'h8;
    localparam int OFS_SETTLE = 'hC;

    // control word bit positions
    localparam int CB_IRQ_ST = 6;
    localparam int CB_IRQ_EN = 5;
    localparam int CB_PWR    = 3;
    localparam int CB_SEL_W  = 3;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int BITS  = 10,
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [DLY_W-1:0] settle,
    input  logic             cmp_hi,
    output logic [BITS-1:0]  dac_code,
    output logic             busy,
    output logic             done,
    output logic [BITS-1:0]  code
);
    localparam int IDX_W = $clog2(BITS);

    sar_state_e       state_q, state_d;
    logic [DLY_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [BITS-1:0]  acc_q;
    logic [BITS-1:0]  bit_sel;

    assign bit_sel = BITS'(1) << idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (settle == '0) ? ST_SEARCH : ST_SETTLE;
            end
            ST_SETTLE: begin
                if (abort)                     state_d = ST_IDLE;
                else if (cnt_q == DLY_W'(1))   state_d = ST_SEARCH;
            end
            ST_SEARCH: begin
                if (abort)                     state_d = ST_IDLE;
                else if (idx_q == '0)          state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        dac_code = '0;
        done     = 1'b0;
        code     = acc_q | (cmp_hi ? bit_sel : '0);
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETTLE: ;
            ST_SEARCH: begin
                dac_code = acc_q | bit_sel;
                done     = (idx_q == '0) && !abort;
            end
            default: ;
        endcase
    end

    // counter, bit index and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            acc_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q <= settle;
                        idx_q <= IDX_W'(BITS - 1);
                        acc_q <= '0;
                    end
                end
                ST_SETTLE: cnt_q <= cnt_q - DLY_W'(1);
                ST_SEARCH: begin
                    if (cmp_hi) acc_q <= acc_q | bit_sel;
                    idx_q <= idx_q - IDX_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int BITS    = 10,
    parameter int DLY_W   = 6,
    parameter int NUM_CH  = 3,
    parameter int CHSEL_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               busy,
    input  logic               done,
    input  logic [BITS-1:0]    code,
    output logic               start,
    output logic               abort,
    output logic [DLY_W-1:0]   settle,
    output logic               irq_st,
    output logic               irq_en,
    output logic               pwr,
    output logic [CHSEL_W-1:0] chan
);
    logic                ctrl_wr;
    logic [CB_SEL_W-1:0] sel_q;
    logic [BITS-1:0]     code_q;
    logic [CHSEL_W-1:0]  sel_dec;
    logic                unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:8];
    assign ctrl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign start   = ctrl_wr &&  wdata[CB_PWR] && !busy;
    assign abort   = ctrl_wr && !wdata[CB_PWR] &&  busy;
    assign sel_dec = (int'(wdata[CB_SEL_W-1:0]) < NUM_CH) ? CHSEL_W'(wdata[CB_SEL_W-1:0]) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_st <= 1'b0;
            irq_en <= 1'b0;
            pwr    <= 1'b0;
            sel_q  <= '0;
            settle <= '0;
            code_q <= '0;
            chan   <= '0;
        end else begin
            if (ctrl_wr) begin
                irq_en <= wdata[CB_IRQ_EN];
                pwr    <= wdata[CB_PWR];
                sel_q  <= wdata[CB_SEL_W-1:0];
            end
            if (start) chan <= sel_dec;
            if (done)                             irq_st <= 1'b1;
            else if (ctrl_wr && !wdata[CB_IRQ_ST]) irq_st <= 1'b0;
            if (done) code_q <= code;
            if (wr_en && (addr == ADDR_W'(OFS_SETTLE))) settle <= wdata[DLY_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_CODE):   rdata[BITS-1:0] = code_q;
            ADDR_W'(OFS_STATUS): rdata[0] = busy;
            ADDR_W'(OFS_CTRL): begin
                rdata[CB_IRQ_ST]      = irq_st;
                rdata[CB_IRQ_EN]      = irq_en;
                rdata[CB_PWR]         = pwr;
                rdata[CB_SEL_W-1:0]   = sel_q;
            end
            ADDR_W'(OFS_SETTLE): rdata[DLY_W-1:0] = settle;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int BITS    = 10,
    parameter int DLY_W   = 6,
    parameter int NUM_CH  = 3,
    parameter int CHSEL_W = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq,
    output logic               adc_pwr,
    output logic [CHSEL_W-1:0] adc_chan,
    output logic [BITS-1:0]    dac_code,
    input  logic               cmp_hi
);
    logic             busy, done, start, abort, irq_st, irq_en;
    logic [DLY_W-1:0] settle;
    logic [BITS-1:0]  code;

    sar_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BITS(BITS),
        .DLY_W(DLY_W), .NUM_CH(NUM_CH), .CHSEL_W(CHSEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
        .code(code), .start(start), .abort(abort), .settle(settle),
        .irq_st(irq_st), .irq_en(irq_en), .pwr(adc_pwr), .chan(adc_chan)
    );

    sar_seq #(.BITS(BITS), .DLY_W(DLY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .settle(settle), .cmp_hi(cmp_hi), .dac_code(dac_code),
        .busy(busy), .done(done), .code(code)
    );

    assign irq = irq_st && irq_en;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int BITS    = 10,
    parameter int DLY_W   = 6,
    parameter int NUM_CH  = 3,
    parameter int CHSEL_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic               irq,
    input logic               adc_pwr,
    input logic [CHSEL_W-1:0] adc_chan,
    input logic [BITS-1:0]    dac_code,
    input logic               busy,
    input logic               start,
    input logic               abort,
    input logic               done,
    input logic               irq_st,
    input logic [DLY_W-1:0]   settle
);
    logic [DLY_W:0]   run_cnt;
    logic [DLY_W-1:0] lat_settle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt    <= '0;
            lat_settle <= '0;
        end else if (start) begin
            run_cnt    <= '0;
            lat_settle <= settle;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_conv_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(run_cnt) == int'(lat_settle) + BITS - 1));

    assert_first_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_code != '0) |-> (dac_code == (BITS'(1) << (BITS - 1))));

    assert_chan_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(adc_chan) < NUM_CH);

    assert_status_from_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_st) |-> $past(busy));

    assert_zero_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'('h8) && wdata == '0) |=> (!irq && !adc_pwr));

    assert_abort_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !irq_st));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BITS(BITS),
    .DLY_W(DLY_W), .NUM_CH(NUM_CH), .CHSEL_W(CHSEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .adc_pwr(adc_pwr), .adc_chan(adc_chan), .dac_code(dac_code),
    .busy(busy), .start(start), .abort(abort), .done(done),
    .irq_st(irq_st), .settle(settle)
);

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_adc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, adc_pwr, cmp_hi;
    logic [1:0]  adc_chan;
    logic [9:0]  dac_code;
    logic [9:0]  vin [3];

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_left = 0, m_res = 0, m_sel = 0, m_dly = 0, m_ch = 0;
    bit m_ie = 0, m_pwr = 0, m_ist = 0;

    always #2.5 clk = ~clk;

    sar_adc_ctrl i_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .adc_pwr(adc_pwr), .adc_chan(adc_chan),
        .dac_code(dac_code), .cmp_hi(cmp_hi)
    );

    assign cmp_hi = (adc_chan < 2'd3) ? (vin[adc_chan] >= dac_code) : 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_res = 0; m_sel = 0; m_dly = 0; m_ch = 0;
            m_ie = 0; m_pwr = 0; m_ist = 0;
        end else begin
            bit busy_b, ctrlw, cancel, fin;
            busy_b = (m_left > 0);
            ctrlw  = wr_en && (addr == 4'h8);
            cancel = ctrlw && !wdata[3] && busy_b;
            fin    = 1'b0;
            if (cancel) m_left = 0;
            else if (busy_b) begin
                m_left--;
                if (m_left == 0) begin
                    m_res = vin[m_sel];
                    fin = 1'b1;
                end
            end
            if (ctrlw) begin
                m_ie = wdata[5]; m_pwr = wdata[3]; m_ch = int'(wdata[2:0]);
                if (!busy_b && wdata[3]) begin
                    m_left = m_dly + 10;
                    m_sel = (wdata[2:0] > 3'd2) ? 0 : int'(wdata[2:0]);
                end
            end
            if (fin) m_ist = 1'b1;
            else if (ctrlw && !wdata[6]) m_ist = 1'b0;
            if (wr_en && addr == 4'hC) m_dly = int'(wdata[5:0]);
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] e;
            case (addr)
                4'h0: e = 32'(m_res);
                4'h4: e = {31'd0, m_left > 0};
                4'h8: e = {25'd0, m_ist, m_ie, 1'b0, m_pwr, 3'(m_ch)};
                4'hC: e = 32'(m_dly);
                default: e = '0;
            endcase
            check("rdata", rdata, e);
            check("irq", {31'd0, irq}, {31'd0, m_ist & m_ie});
            check("adc_pwr", {31'd0, adc_pwr}, {31'd0, m_pwr});
            check("adc_chan", {30'd0, adc_chan}, 32'(m_sel));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic idle(input int n, input logic [3:0] a);
        addr = a;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        vin[0] = 10'd700; vin[1] = 10'd3; vin[2] = 10'd1023;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";  idle(2, 4'h0); idle(2, 4'h4); idle(2, 4'h8); idle(2, 4'hC);
        cur_req = "R3";  wr(4'hC, 32'h48); idle(2, 4'hC);
        cur_req = "R2";  wr(4'h8, 32'h28); idle(20, 4'h4);
        cur_req = "R4";  idle(2, 4'h0);
        cur_req = "R6";  idle(2, 4'h8);
        cur_req = "R7";  wr(4'h8, 32'h0); idle(3, 4'h8);
        cur_req = "R3";  wr(4'hC, 32'h0); wr(4'h8, 32'h29); idle(12, 4'h4); idle(1, 4'h0);
        cur_req = "R6";  wr(4'h8, 32'h0); wr(4'h8, 32'h0A); idle(12, 4'h8); idle(1, 4'h0);
        cur_req = "R5";  wr(4'h8, 32'h0); vin[0] = 10'd512; wr(4'h8, 32'h2D); idle(12, 4'h0);
        wr(4'h8, 32'h0); vin[0] = 10'd0; wr(4'h8, 32'h2B); idle(12, 4'h0);
        cur_req = "R8";  wr(4'h8, 32'h0); wr(4'hC, 32'h8); vin[1] = 10'd100;
        wr(4'h8, 32'h29); idle(5, 4'h4); wr(4'h8, 32'h20); idle(3, 4'h0); idle(2, 4'h8);
        wr(4'h8, 32'h29); idle(12, 4'h4); wr(4'h8, 32'h20); idle(8, 4'h0);
        cur_req = "R10"; vin[0] = 10'd333; wr(4'h8, 32'h28); idle(3, 4'h4);
        wr(4'h8, 32'h29); idle(16, 4'h4); idle(2, 4'h0); idle(1, 4'h8);
        cur_req = "R9";  idle(1, 4'h1); idle(1, 4'h2); idle(1, 4'h6); idle(1, 4'hE);
        wr(4'h4, 32'hFFFF_FFFF); idle(1, 4'h4);
        wr(4'hC, 32'hFFFF_FFC0); idle(1, 4'hC);
        wr(4'h8, 32'hFFFF_FF40); idle(2, 4'h8);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL %s watchdog expired actual=running expected=done", cur_req);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule